// File: doc/BRIEF.md
# Dithered Sine Synthesizer with Dual-Edge Sample Lanes

This block is a direct digital synthesizer for a tiny resistor-ladder converter. Each enabled clock, a 48-bit phase register advances by a programmable tuning word. The phase selects one entry of a 16-entry sine table with 5-bit amplitudes. With a system clock of 100 MHz, a tuning word of about 0.27 times 2^48 places the tone near 27 MHz, and small changes to the word move it by roughly one percent either way.

The ladder has only four inputs, so each 5-bit amplitude is reduced to 4 bits. The dropped least significant bit is rounded up or down under control of a pseudo-random bit. Every clock the block produces two such samples. One sample is for the rising-edge half of a double-data-rate output register pair, and the other is for the falling-edge half, so the 4-bit code changes at twice the system clock rate. The falling-edge sample is taken at a phase half a tuning step ahead of the rising-edge sample.

Top module: `ddsDither4`

## Requirements
- R1: An active-low asynchronous reset clears the phase register to zero, loads the dither generator with its seed, and sets both sample lanes to mid-scale, code 8.
- R2: On each clock where `en` is high, the phase register gains `freqWord`, modulo 2^48.
- R3: The table index is phase bits [47:44]. Index k returns round(15.5 + 15.5·sin(2π(k+0.5)/16)), which gives, for k = 0..15: 19, 24, 28, 31, 31, 28, 24, 19, 12, 7, 3, 0, 0, 3, 7, 12. Because of this table, the lane codes 5, 8, 11 and 13 never appear once sampling has begun.
- R4: On an enabled clock, `laneRise` is loaded with amplitude[4:1] plus (amplitude[0] AND dither bit 0). The amplitude is looked up from the phase value held before that clock's update.
- R5: On the same clock, `laneFall` is loaded in the same way. It uses the phase plus floor(`freqWord`/2) and dither bit 8.
- R6: A dithered sum that would reach 16 is clamped to 15. It never wraps to 0.
- R7: The dither bits come from a 16-bit shift register seeded with 0xACE1. On each enabled clock it shifts left, and the new bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10. The state is never zero.
- R8: While `en` is low, the phase, the dither state and both lanes hold their values.
- R9: After reset, both lanes stay at 8 until the first clock with `en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance phase and produce a new sample pair |
| freqWord | input | 48 | Phase increment per clock |
| laneRise | output | 4 | Sample for the rising-edge output register |
| laneFall | output | 4 | Sample for the falling-edge output register |

## Verification
Two functions can fall in the same sample: rounding up by dither and clamping at full scale. This happens when the index selects one of the two 31 entries and the chosen dither bit is 1. A tuning word of 2^44 walks the table one entry per clock, so the peak entries come back every sixteen clocks on both lanes. Over many clocks the shift register supplies both values of the dither bit. The bench models the table and the shift register from the requirements. It expects 15 in those samples, never 0, and the check is labelled R6.

// File: rtl/ddsPkg.sv
package ddsPkg;
  localparam int IDX_W = 4;
  localparam int AMP_W = 5;
  localparam int OUT_W = AMP_W - 1;

  typedef struct packed {
    logic step;
    logic ditherRise;
    logic ditherFall;
  } ddsStrobe_t;

  // quarter-offset sine samples, full 5-bit swing
  function automatic logic [AMP_W-1:0] sineAmp(input logic [IDX_W-1:0] idx);
    logic [AMP_W-1:0] amp;
    case (idx)
      4'd0, 4'd7:   amp = 5'd19;
      4'd1, 4'd6:   amp = 5'd24;
      4'd2, 4'd5:   amp = 5'd28;
      4'd3, 4'd4:   amp = 5'd31;
      4'd8, 4'd15:  amp = 5'd12;
      4'd9, 4'd14:  amp = 5'd7;
      4'd10, 4'd13: amp = 5'd3;
      default:      amp = 5'd0;
    endcase
    return amp;
  endfunction

  // drop the LSB, round up when both LSB and dither are set, clamp at top
  function automatic logic [OUT_W-1:0] ditherAmp(input logic [AMP_W-1:0] amp, input logic dith);
    logic [OUT_W:0] sum;
    sum = {1'b0, amp[AMP_W-1:1]} + {{OUT_W{1'b0}}, amp[0] & dith};
    return sum[OUT_W] ? {OUT_W{1'b1}} : sum[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/ddsCtrl.sv
module ddsCtrl #(
  parameter int              LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
  parameter int              RISE_BIT = 0,
  parameter int              FALL_BIT = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                en,
  output ddsPkg::ddsStrobe_t  strobe
);
  logic [LFSR_W-1:0] lfsrQ;
  logic              feedback;

  assign feedback = ^(lfsrQ & TAPS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   lfsrQ <= SEED;
    else if (en) lfsrQ <= {lfsrQ[LFSR_W-2:0], feedback};
  end

  always_comb begin
    strobe.step       = en;
    strobe.ditherRise = lfsrQ[RISE_BIT];
    strobe.ditherFall = lfsrQ[FALL_BIT];
  end
endmodule

// File: rtl/ddsDatapath.sv
module ddsDatapath
  import ddsPkg::*;
#(
  parameter int PHASE_W = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PHASE_W-1:0] freqWord,
  input  ddsStrobe_t         strobe,
  output logic [OUT_W-1:0]   laneRise,
  output logic [OUT_W-1:0]   laneFall
);
  localparam int               LANES = 2;
  localparam logic [OUT_W-1:0] MID   = {1'b1, {(OUT_W-1){1'b0}}};

  logic [PHASE_W-1:0] phaseQ;
  logic [PHASE_W-1:0] lanePhase  [LANES];
  logic [OUT_W-1:0]   laneSample [LANES];
  logic [OUT_W-1:0]   laneQ      [LANES];
  logic [LANES-1:0]   laneDither;

  assign laneDither = {strobe.ditherFall, strobe.ditherRise};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phaseQ <= '0;
    else if (strobe.step) phaseQ <= phaseQ + freqWord;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    if (g == 0) begin : gOnEdge
      assign lanePhase[g] = phaseQ;
    end else begin : gHalfStep
      assign lanePhase[g] = phaseQ + (freqWord >> 1);
    end

    always_comb
      laneSample[g] = ditherAmp(sineAmp(lanePhase[g][PHASE_W-1 -: IDX_W]), laneDither[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            laneQ[g] <= MID;
      else if (strobe.step) laneQ[g] <= laneSample[g];
    end
  end

  assign laneRise = laneQ[0];
  assign laneFall = laneQ[1];
endmodule

// File: rtl/ddsDither4.sv
module ddsDither4 #(
  parameter int PHASE_W = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               en,
  input  logic [PHASE_W-1:0] freqWord,
  output logic [3:0]         laneRise,
  output logic [3:0]         laneFall
);
  ddsPkg::ddsStrobe_t strobe;

  ddsCtrl ctl (
    .clk    (clk),
    .rstN   (rstN),
    .en     (en),
    .strobe (strobe)
  );

  ddsDatapath #(.PHASE_W(PHASE_W)) dp (
    .clk      (clk),
    .rstN     (rstN),
    .freqWord (freqWord),
    .strobe   (strobe),
    .laneRise (laneRise),
    .laneFall (laneFall)
  );
endmodule

// File: rtl/ddsDitherChecker.sv
module ddsDitherChecker #(
  parameter int PHASE_W = 48,
  parameter int LFSR_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               en,
  input logic [3:0]         laneRise,
  input logic [3:0]         laneFall,
  input logic [PHASE_W-1:0] phaseQ,
  input logic [LFSR_W-1:0]  lfsrQ
);
  logic primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   primed <= 1'b0;
    else if (en) primed <= 1'b1;
  end

  assert_mid_scale_R9: assert property (@(posedge clk) disable iff (!rstN)
    !primed |-> (laneRise == 4'd8 && laneFall == 4'd8));

  assert_code_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> !(laneRise inside {4'd5, 4'd8, 4'd11, 4'd13}) &&
               !(laneFall inside {4'd5, 4'd8, 4'd11, 4'd13}));

  assert_lane_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> ($stable(laneRise) && $stable(laneFall)));

  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(phaseQ));

  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);
endmodule

bind ddsDither4 ddsDitherChecker #(.PHASE_W(PHASE_W), .LFSR_W(16)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .en       (en),
  .laneRise (laneRise),
  .laneFall (laneFall),
  .phaseQ   (dp.phaseQ),
  .lfsrQ    (ctl.lfsrQ)
);

// File: tb/tb_ddsDither4.sv
module tb_ddsDither4;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0;
  logic [47:0] freqWord = '0;
  logic [3:0]  laneRise, laneFall;

  int checks = 0;
  int fails  = 0;

  logic [47:0] mPhase;
  logic [15:0] mLfsr;
  logic [3:0]  expR, expF;
  string       tagR, tagF;

  localparam int NVEC = 5;
  localparam logic [47:0] VEC_FREQ [NVEC] = '{
    48'h1000_0000_0000, 48'h4511_EB85_1EB8, 48'hFFFF_FFFF_FFFF,
    48'h0000_0000_0001, 48'h8000_0000_0000 };
  localparam int VEC_LEN [NVEC] = '{40, 32, 24, 12, 16};

  ddsDither4 dut (
    .clk(clk), .rstN(rstN), .en(en), .freqWord(freqWord),
    .laneRise(laneRise), .laneFall(laneFall));

  always #5 clk = ~clk;

  function automatic logic [4:0] refAmp(input logic [3:0] i);
    logic [4:0] t [16];
    t = '{5'd19, 5'd24, 5'd28, 5'd31, 5'd31, 5'd28, 5'd24, 5'd19,
          5'd12, 5'd7, 5'd3, 5'd0, 5'd0, 5'd3, 5'd7, 5'd12};
    return t[i];
  endfunction

  function automatic logic [3:0] refOut(input logic [47:0] ph, input logic d);
    logic [4:0] a;
    int v;
    a = refAmp(ph[47:44]);
    v = int'(a[4:1]) + ((a[0] && d) ? 1 : 0);
    if (v > 15) v = 15;
    return 4'(v);
  endfunction

  function automatic string tagFor(input logic [47:0] ph, input logic d, input string base);
    if (refAmp(ph[47:44]) == 5'd31 && d) return "R6";
    return base;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic resetModel();
    mPhase = '0; mLfsr = 16'hACE1; expR = 4'd8; expF = 4'd8;
  endtask

  task automatic step(input logic e, input logic [47:0] f, input string holdTag);
    @(negedge clk);
    en = e; freqWord = f;
    if (e) begin
      expR = refOut(mPhase, mLfsr[0]);
      expF = refOut(mPhase + (f >> 1), mLfsr[8]);
      tagR = tagFor(mPhase, mLfsr[0], "R2 R3 R4 R7");
      tagF = tagFor(mPhase + (f >> 1), mLfsr[8], "R3 R5 R7");
      mPhase = mPhase + f;
      mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
    end else begin
      tagR = holdTag; tagF = holdTag;
    end
    @(posedge clk); #1;
    check(tagR, laneRise, expR);
    check(tagF, laneFall, expF);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    resetModel();
    repeat (3) @(posedge clk);
    #1;
    check("R1", laneRise, 4'd8);
    check("R1", laneFall, 4'd8);
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 48'h1000_0000_0000, "R9");

    for (int v = 0; v < NVEC; v++) begin
      for (int c = 0; c < VEC_LEN[v]; c++) step(1'b1, VEC_FREQ[v], "");
      for (int c = 0; c < 3; c++) step(1'b0, VEC_FREQ[v], "R8");
    end

    // mid-run reset, then walk the table from a cleared phase
    @(negedge clk); rstN = 1'b0; en = 1'b0;
    #1;
    resetModel();
    check("R1", laneRise, 4'd8);
    check("R1", laneFall, 4'd8);
    @(negedge clk); rstN = 1'b1;
    step(1'b0, 48'h1000_0000_0000, "R9");
    for (int c = 0; c < 48; c++) step(1'b1, 48'h1000_0000_0000, "");
    // enable toggling: held samples then resumed phase
    for (int c = 0; c < 20; c++) step(c[0], 48'h2340_0000_0001, "R8");

    finishRun();
  end
endmodule